// File: doc/BRIEF.md
# ATA-over-MMC Error Recovery Sequencer

This block sits in the control path of an MMC host that carries ATA commands to a storage device. It watches the result of every ATA transaction and sorts failures into two kinds. Link-level failures are a missing response, a bad command or response CRC, a bad data-block CRC, or a completion signal that never arrives. Any of these starts a fixed recovery ladder. An ATA status error reported over a clean link needs no recovery, and the block only signals that the host may retry the ATA command.

The block raises recovery commands one at a time on a request/acknowledge port. The port carries a 6-bit command index and a flag that selects the completion-signal-disable token instead of an indexed command. Each acknowledge returns a 2-bit status. The ladder runs in a fixed order: an optional completion-signal disable, then the stop command (index 12), then the fast-I/O software reset (index 39). If all of them succeed, the block pulses `recovered`. If any step comes back with a bad status, the block sends the go-idle hard reset (index 0) and pulses `need_reinit`, which tells the host to repeat the whole device bring-up.

A built-in down-counter enforces the completion timeout. The counter is loaded when an ATA command starts and stops when the completion signal arrives.

Top module: `ata_err_recovery`

## Requirements
- R1: After synchronous reset, `busy`, `cmd_req`, `recovered`, `need_reinit` and `retry_ok` are all low.
- R2: A `txn_done` cycle with any of `rsp_missing`, `cmd_crc_bad` or `dat_crc_bad` set, while idle, is a link failure. `busy` is high in the cycle after that edge.
- R3: A `txn_done` cycle with only `ata_err` set, while idle, raises no command and leaves `busy` low. `retry_ok` pulses high for exactly one cycle after that edge.
- R4: An edge with `txn_start` high loads the timeout with `tmo_cycles` (N). If `ccs_arrive` has not been seen, `busy` is still low N cycles after that edge and is high N+1 cycles after it. A `ccs_arrive` before expiry cancels the timeout.
- R5: The first recovery command is the completion-signal-disable token (`cmd_ccsd`=1, `cmd_idx`=0) exactly when `ien` was 0 and `r61_seen` was 1 at the failure. Otherwise the first command is index 12.
- R6: With every status OK, the commands run in the order: disable token (if R5 applies), index 12, index 39. The acknowledge of index 39 makes `recovered` pulse for one cycle and drops `busy`.
- R7: A status other than OK (0=OK, 1=timeout, 2=CRC error, 3 also treated as error) on any ladder step makes the next command index 0 with `cmd_ccsd`=0.
- R8: The acknowledge of index 0, whatever its status, makes `need_reinit` pulse for one cycle and drops `busy`.
- R9: Once `cmd_req` is high, it and `cmd_idx`/`cmd_ccsd` hold steady until an acknowledge. Only one command is ever outstanding.
- R10: Failures and ATA-only errors reported while `busy` is high are ignored. They change neither the command sequence nor the outcome, and they produce no `retry_ok`.
- R11: `busy` stays high from the cycle after detection until the cycle in which `recovered` or `need_reinit` pulses. It falls only together with one of those pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | ATA command started; loads the completion timeout |
| tmo_cycles | input | TMR_W | Completion timeout length in cycles |
| ccs_arrive | input | 1 | Completion signal received; stops the timeout |
| txn_done | input | 1 | Transaction outcome valid this cycle |
| rsp_missing | input | 1 | No response to an MMC command |
| cmd_crc_bad | input | 1 | Command or response CRC invalid |
| dat_crc_bad | input | 1 | Data block CRC16 invalid |
| ata_err | input | 1 | ATA status ERR bit set |
| ien | input | 1 | Device interrupt-enable bit state |
| r61_seen | input | 1 | Response to the multi-block ATA command received |
| cmd_req | output | 1 | Recovery command request |
| cmd_idx | output | IDX_W | Recovery command index |
| cmd_ccsd | output | 1 | Request is the completion-signal-disable token |
| cmd_ack | input | 1 | Command engine finished the request |
| cmd_sts | input | 2 | Status with the acknowledge: 0 OK, 1 timeout, 2 CRC error |
| busy | output | 1 | Recovery in progress |
| recovered | output | 1 | One-cycle pulse: recovery succeeded |
| need_reinit | output | 1 | One-cycle pulse: hard reset sent, re-initialise device |
| retry_ok | output | 1 | One-cycle pulse: ATA-level error only, retry allowed |

## Verification
The bench builds the block with `TMR_W`=6, so a timeout of 0 and the full 63-cycle count both fit in short runs, and it keeps the default `IDX_W`=6. At that width the exact cycle of expiry can be checked at both ends of the range, as can an arrival that cancels the count just before expiry. The command indices stay at 12, 39 and 0, so every branch of the ladder shows on `cmd_idx`: the disable token with and without its enabling conditions, a failure at each step, and late failures injected while a recovery is running.

// File: rtl/ata_rec_pkg.sv
package ata_rec_pkg;

  typedef enum logic [1:0] {
    RSP_OK  = 2'd0,
    RSP_TMO = 2'd1,
    RSP_CRC = 2'd2,
    RSP_BAD = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CCSD = 3'd1,
    ST_STOP = 3'd2,
    ST_FIO  = 3'd3,
    ST_HARD = 3'd4
  } step_e;

endpackage

// File: rtl/ata_rec_timer.sv
module ata_rec_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [TMR_W-1:0] load_val,
  input  logic             arrive,
  output logic             expire
);

  logic [TMR_W-1:0] cnt_q;
  logic             armed_q;

  // Arrival in the same cycle as a zero count still cancels the timeout.
  assign expire = armed_q && (cnt_q == '0) && !arrive;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (arrive || cnt_q == '0) begin
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ata_rec_classify.sv
module ata_rec_classify (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic txn_done,
  input  logic rsp_missing,
  input  logic cmd_crc_bad,
  input  logic dat_crc_bad,
  input  logic ata_err,
  input  logic tmo_expire,
  input  logic ien,
  input  logic r61_seen,
  output logic fault,
  output logic ccs_need,
  output logic retry_ok
);

  logic link_err;
  logic ata_only;

  assign link_err = txn_done && (rsp_missing || cmd_crc_bad || dat_crc_bad);
  assign fault    = !busy && (link_err || tmo_expire);
  assign ata_only = !busy && txn_done && ata_err && !link_err && !tmo_expire;
  assign ccs_need = !ien && r61_seen;

  always_ff @(posedge clk) begin
    if (rst) retry_ok <= 1'b0;
    else     retry_ok <= ata_only;
  end

endmodule

// File: rtl/ata_rec_seq.sv
module ata_rec_seq
  import ata_rec_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int STOP_IDX = 12,
  parameter int FIO_IDX  = 39,
  parameter int HARD_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault,
  input  logic             ccs_need,
  output logic             cmd_req,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_ccsd,
  input  logic             cmd_ack,
  input  logic [1:0]       cmd_sts,
  output logic             busy,
  output logic             recovered,
  output logic             need_reinit
);

  step_e state_q;

  function automatic logic [IDX_W-1:0] step_index(step_e s);
    case (s)
      ST_STOP: step_index = IDX_W'(STOP_IDX);
      ST_FIO:  step_index = IDX_W'(FIO_IDX);
      ST_HARD: step_index = IDX_W'(HARD_IDX);
      default: step_index = '0;
    endcase
  endfunction

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cmd_req     <= 1'b0;
      cmd_idx     <= '0;
      cmd_ccsd    <= 1'b0;
      recovered   <= 1'b0;
      need_reinit <= 1'b0;
    end else begin
      recovered   <= 1'b0;
      need_reinit <= 1'b0;
      if (state_q == ST_IDLE) begin
        cmd_req <= 1'b0;
        if (fault) state_q <= ccs_need ? ST_CCSD : ST_STOP;
      end else if (!cmd_req) begin
        cmd_req  <= 1'b1;
        cmd_idx  <= step_index(state_q);
        cmd_ccsd <= (state_q == ST_CCSD);
      end else if (cmd_ack) begin
        cmd_req <= 1'b0;
        if (state_q == ST_HARD) begin
          state_q     <= ST_IDLE;
          need_reinit <= 1'b1;
        end else if (rsp_e'(cmd_sts) != RSP_OK) begin
          state_q <= ST_HARD;
        end else begin
          case (state_q)
            ST_CCSD: state_q <= ST_STOP;
            ST_STOP: state_q <= ST_FIO;
            default: begin
              state_q   <= ST_IDLE;
              recovered <= 1'b1;
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/ata_err_recovery.sv
module ata_err_recovery #(
  parameter int TMR_W    = 16,
  parameter int IDX_W    = 6,
  parameter int STOP_IDX = 12,
  parameter int FIO_IDX  = 39,
  parameter int HARD_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic [TMR_W-1:0] tmo_cycles,
  input  logic             ccs_arrive,
  input  logic             txn_done,
  input  logic             rsp_missing,
  input  logic             cmd_crc_bad,
  input  logic             dat_crc_bad,
  input  logic             ata_err,
  input  logic             ien,
  input  logic             r61_seen,
  output logic             cmd_req,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_ccsd,
  input  logic             cmd_ack,
  input  logic [1:0]       cmd_sts,
  output logic             busy,
  output logic             recovered,
  output logic             need_reinit,
  output logic             retry_ok
);

  logic tmo_expire;
  logic fault;
  logic ccs_need;

  ata_rec_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (txn_start),
    .load_val (tmo_cycles),
    .arrive   (ccs_arrive),
    .expire   (tmo_expire)
  );

  ata_rec_classify u_classify (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .txn_done    (txn_done),
    .rsp_missing (rsp_missing),
    .cmd_crc_bad (cmd_crc_bad),
    .dat_crc_bad (dat_crc_bad),
    .ata_err     (ata_err),
    .tmo_expire  (tmo_expire),
    .ien         (ien),
    .r61_seen    (r61_seen),
    .fault       (fault),
    .ccs_need    (ccs_need),
    .retry_ok    (retry_ok)
  );

  ata_rec_seq #(
    .IDX_W    (IDX_W),
    .STOP_IDX (STOP_IDX),
    .FIO_IDX  (FIO_IDX),
    .HARD_IDX (HARD_IDX)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .fault       (fault),
    .ccs_need    (ccs_need),
    .cmd_req     (cmd_req),
    .cmd_idx     (cmd_idx),
    .cmd_ccsd    (cmd_ccsd),
    .cmd_ack     (cmd_ack),
    .cmd_sts     (cmd_sts),
    .busy        (busy),
    .recovered   (recovered),
    .need_reinit (need_reinit)
  );

endmodule

// File: rtl/ata_err_recovery_chk.sv
module ata_err_recovery_chk #(
  parameter int IDX_W    = 6,
  parameter int FIO_IDX  = 39,
  parameter int HARD_IDX = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_req,
  input logic [IDX_W-1:0] cmd_idx,
  input logic             cmd_ccsd,
  input logic             cmd_ack,
  input logic [1:0]       cmd_sts,
  input logic             busy,
  input logic             recovered,
  input logic             need_reinit,
  input logic             retry_ok
);

  // R9: request and its payload hold until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_idx) && $stable(cmd_ccsd)));

  // R11: busy only falls together with an outcome pulse
  p_busy_end_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (recovered || need_reinit));

  // R8: reinit follows an acknowledged hard reset
  p_reinit_cause_r8: assert property (@(posedge clk) disable iff (rst)
    need_reinit |-> $past(cmd_req && cmd_ack && !cmd_ccsd && cmd_idx == IDX_W'(HARD_IDX)));

  // R6: success follows a clean fast-I/O reset
  p_recover_cause_r6: assert property (@(posedge clk) disable iff (rst)
    recovered |-> $past(cmd_req && cmd_ack && !cmd_ccsd && cmd_idx == IDX_W'(FIO_IDX) && cmd_sts == 2'd0));

  // R3: outcome pulses never overlap
  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({recovered, need_reinit, retry_ok}));

  // R10: no command request outside a recovery
  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> busy);

endmodule

bind ata_err_recovery ata_err_recovery_chk #(
  .IDX_W    (IDX_W),
  .FIO_IDX  (FIO_IDX),
  .HARD_IDX (HARD_IDX)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_req     (cmd_req),
  .cmd_idx     (cmd_idx),
  .cmd_ccsd    (cmd_ccsd),
  .cmd_ack     (cmd_ack),
  .cmd_sts     (cmd_sts),
  .busy        (busy),
  .recovered   (recovered),
  .need_reinit (need_reinit),
  .retry_ok    (retry_ok)
);

// File: tb/ata_err_recovery_bench.sv
module ata_err_recovery_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TMR_W      = 6;
  localparam int IDX_W      = 6;
  localparam int CODE_CCSD  = 100;

  logic             clk = 1'b0;
  logic             rst;
  logic             txn_start, ccs_arrive, txn_done;
  logic [TMR_W-1:0] tmo_cycles;
  logic             rsp_missing, cmd_crc_bad, dat_crc_bad, ata_err, ien, r61_seen;
  logic             cmd_req, cmd_ccsd, cmd_ack;
  logic [IDX_W-1:0] cmd_idx;
  logic [1:0]       cmd_sts;
  logic             busy, recovered, need_reinit, retry_ok;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_err_recovery #(.TMR_W(TMR_W), .IDX_W(IDX_W)) u_ata_err_recovery (
    .clk(clk), .rst(rst), .txn_start(txn_start), .tmo_cycles(tmo_cycles),
    .ccs_arrive(ccs_arrive), .txn_done(txn_done), .rsp_missing(rsp_missing),
    .cmd_crc_bad(cmd_crc_bad), .dat_crc_bad(dat_crc_bad), .ata_err(ata_err),
    .ien(ien), .r61_seen(r61_seen), .cmd_req(cmd_req), .cmd_idx(cmd_idx),
    .cmd_ccsd(cmd_ccsd), .cmd_ack(cmd_ack), .cmd_sts(cmd_sts), .busy(busy),
    .recovered(recovered), .need_reinit(need_reinit), .retry_ok(retry_ok)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_code(bit ien_v, bit r61_v);
    return (!ien_v && r61_v) ? CODE_CCSD : 12;
  endfunction

  function automatic int next_code(int cur);
    return (cur == CODE_CCSD) ? 12 : 39;
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic clear_in;
    txn_start = 0; ccs_arrive = 0; txn_done = 0;
    rsp_missing = 0; cmd_crc_bad = 0; dat_crc_bad = 0; ata_err = 0;
    cmd_ack = 0; cmd_sts = 0;
  endtask

  // Services the ladder; fail_at: position of the step given a bad status (-1 none).
  task automatic service(bit ien_v, bit r61_v, int fail_at, bit inject);
    int  code = first_code(ien_v, r61_v);
    int  pos  = 0;
    bit  hard = 0;
    bit  done = 0;
    bit  first = 1;
    while (!done) begin
      int waitc = 0;
      while (!cmd_req && waitc < 20) begin
        if (inject && first) begin
          txn_done = 1; cmd_crc_bad = 1; ata_err = 1;
        end
        tick;
        txn_done = 0; cmd_crc_bad = 0; ata_err = 0;
        if (inject && first) chk(retry_ok == 0, "R10 no retry while busy", retry_ok, 0);
        first = 0;
        waitc++;
      end
      if (!cmd_req) begin
        chk(0, "R9 request missing", 0, 1);
        return;
      end
      begin
        int act = cmd_ccsd ? CODE_CCSD : int'(cmd_idx);
        int exp = hard ? 0 : code;
        logic [1:0] s;
        if (pos == 0 && !hard) chk(act == exp, "R5 first command", act, exp);
        else if (hard)         chk(act == exp, "R7 hard reset index", act, exp);
        else                   chk(act == exp, "R6 ladder order", act, exp);
        repeat ($urandom_range(0, 2)) tick;
        chk(cmd_req == 1, "R9 request held", cmd_req, 1);
        if (hard) s = 2'($urandom_range(0, 3));
        else if (pos == fail_at) s = 2'($urandom_range(1, 3));
        else s = 2'd0;
        cmd_ack = 1; cmd_sts = s;
        tick;
        cmd_ack = 0; cmd_sts = 0;
        if (hard) begin
          chk(need_reinit == 1 && busy == 0, "R8 reinit pulse", {need_reinit, busy}, 2);
          tick;
          chk(need_reinit == 0, "R8 reinit one cycle", need_reinit, 0);
          done = 1;
        end else if (s != 0) begin
          hard = 1;
          chk(busy == 1 && recovered == 0, "R11 busy after failed step", busy, 1);
        end else if (code == 39) begin
          chk(recovered == 1 && busy == 0, "R6 recovered pulse", {recovered, busy}, 2);
          tick;
          chk(recovered == 0, "R6 recovered one cycle", recovered, 0);
          done = 1;
        end else begin
          chk(busy == 1, "R11 busy mid ladder", busy, 1);
          code = next_code(code);
          pos++;
        end
      end
    end
  endtask

  task automatic link_fault(int kind);
    txn_done = 1;
    rsp_missing = (kind == 0);
    cmd_crc_bad = (kind == 1);
    dat_crc_bad = (kind == 2);
    tick;
    txn_done = 0; rsp_missing = 0; cmd_crc_bad = 0; dat_crc_bad = 0;
    chk(busy == 1, "R2 busy after link failure", busy, 1);
  endtask

  task automatic timer_fault(int n);
    tmo_cycles = TMR_W'(n);
    txn_start = 1;
    tick;
    txn_start = 0;
    repeat (n) tick;
    chk(busy == 0, "R4 not before expiry", busy, 0);
    tick;
    chk(busy == 1, "R4 busy at expiry", busy, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4711));
    clear_in;
    ien = 1; r61_seen = 0; tmo_cycles = 0;
    rst = 1;
    repeat (3) tick;
    rst = 0;
    tick;
    chk({busy, cmd_req, recovered, need_reinit, retry_ok} == 5'b0, "R1 reset state",
        {busy, cmd_req, recovered, need_reinit, retry_ok}, 0);

    // R3: ATA-only error
    txn_done = 1; ata_err = 1;
    tick;
    txn_done = 0; ata_err = 0;
    chk(retry_ok == 1 && busy == 0, "R3 retry pulse", {retry_ok, busy}, 2);
    tick;
    chk(retry_ok == 0 && cmd_req == 0 && busy == 0, "R3 retry one cycle", {retry_ok, cmd_req, busy}, 0);

    // R4: arrival cancels the timeout
    tmo_cycles = 6'd5; txn_start = 1;
    tick;
    txn_start = 0;
    repeat (4) tick;
    ccs_arrive = 1;
    tick;
    ccs_arrive = 0;
    repeat (10) tick;
    chk(busy == 0, "R4 arrival cancels timeout", busy, 0);

    // R4 boundaries, R5 with and without the disable token
    ien = 0; r61_seen = 1;
    timer_fault(0);
    service(0, 1, -1, 0);
    ien = 1;
    timer_fault(63);
    service(1, 1, -1, 0);

    // R7 directed: failure at each ladder step
    ien = 0; r61_seen = 1;
    for (int p = 0; p < 3; p++) begin
      link_fault(p);
      service(0, 1, p, 0);
    end

    // Random trials
    for (int t = 0; t < 60; t++) begin
      bit ie = 1'($urandom_range(0, 1));
      bit rs = 1'($urandom_range(0, 1));
      int kind = $urandom_range(0, 3);
      int steps = (!ie && rs) ? 3 : 2;
      int fa = ($urandom_range(0, 1) == 1) ? $urandom_range(0, steps - 1) : -1;
      ien = ie; r61_seen = rs;
      if (kind == 3) timer_fault($urandom_range(0, 12));
      else link_fault(kind);
      service(ie, rs, fa, 1'($urandom_range(0, 1)));
      repeat ($urandom_range(1, 3)) tick;
      chk(busy == 0 && cmd_req == 0, "R11 idle between trials", {busy, cmd_req}, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule